// File: doc/BRIEF.md
# Front-end configuration shift chain

This controller writes the setting registers of a string of external amplifier chips over five dedicated wires. The host hands it a whole configuration word and a start pulse. The controller then produces a slow serial clock from the system clock. It presents the word one bit per serial clock on its data output. The chips pass the word through their shift cells, and all of the cascaded chips form one long shift register. Once the last bit is in, the controller raises a load strobe. The strobe copies every shift cell into the chip's shadow cell, so the outputs that set thresholds and shaping stay steady while a new word is moving through.

The far end of the string returns to the controller's serial input. While the new word goes in, the old chain contents come out and are collected into a readback word. The host can therefore confirm any write by repeating it: the readback of the second transfer must equal the first word. A direction line is held at a host-chosen value for the whole transfer. The block also keeps a 12-bit general output register and brings 3 general input pins into the clock domain.

Top module: `fe_cfg_chain`

## Requirements
- R1: While reset is held, and until the first start, the outputs have these values: ch_clk, ch_load, ch_down, ch_out, busy and done are low, and gpo and rd_data are zero.
- R2: An accepted start produces exactly CHAIN_LEN rising edges on ch_clk. CHAIN_LEN equals CHIPS times CHIP_BITS, which is 48 by default.
- R3: ch_out changes only at the falling edge of ch_clk or while ch_clk is low. It is stable during every high phase. Each clock phase lasts CLK_DIV system cycles.
- R4: The bit order is as follows. wr_data bit 0 is presented first. After the transfer, the chain cell at distance j from the return end (cell 0 drives ch_in) holds wr_data[j].
- R5: ch_in is sampled at each rising edge of ch_clk. The k-th sample (counting from 0) is bit k of rd_data, which is updated when done pulses. As a result, rd_data equals the chain contents from before the transfer.
- R6: After the last shift, ch_load is high for 2*CLK_DIV system cycles while ch_clk stays low. The shadow cells change only on that pulse and keep their old value while bits are shifting.
- R7: ch_down equals the down_cfg value captured with start, holds that value for the whole transfer, and is low when idle.
- R8: busy is high from the cycle after the start edge. done is a single-cycle pulse that occurs 2*CLK_DIV*(CHAIN_LEN+1) cycles after the start edge, and busy falls in the same cycle.
- R9: A start asserted while busy is ignored. The transfer in progress completes with its own word, and no second transfer follows.
- R10: gpo takes gpo_wdata in the cycle after gpo_we is high. When gpo_we is low, gpo holds its value whatever gpo_wdata does.
- R11: The gpi pins pass through two flip-flops. A change appears on gpi_q after the second rising clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain update |
| down_cfg | input | 1 | Direction level for the next transfer |
| wr_data | input | CHAIN_LEN | Configuration word, bit 0 shifted first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | CHAIN_LEN | Bits returned during the last transfer |
| ch_out | output | 1 | Serial data to the first chip |
| ch_down | output | 1 | Direction line to the chips |
| ch_clk | output | 1 | Serial chain clock |
| ch_load | output | 1 | Shift-to-shadow copy strobe |
| ch_in | input | 1 | Serial data returned from the last chip |
| gpo_we | input | 1 | General output write enable |
| gpo_wdata | input | GPO_W | General output write value |
| gpo | output | GPO_W | General output pins |
| gpi | input | GPI_W | General input pins |
| gpi_q | output | GPI_W | Synchronized general inputs |

## Verification
If the bit counter is off by one, the chain contents are shifted by one position. The count of ch_clk rises is wrong, and the readback word is misaligned. All three show at the end of the same transfer, and the load pulse arrives a full clock period early or late. A wrong phase counter shows as a wrong transfer length in cycles. A lost direction latch is visible at the first rising edge of ch_clk. A shift register that moves in the wrong direction leaves the chain holding the bit-reversed word, which the first asymmetric pattern exposes.

// File: rtl/fe_cfg_chain.sv
module fe_cfg_chain #(
  parameter int CHIP_BITS = 16,
  parameter int CHIPS     = 3,
  parameter int CLK_DIV   = 2,
  parameter int GPO_W     = 12,
  parameter int GPI_W     = 3,
  localparam int CHAIN_LEN = CHIPS * CHIP_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 down_cfg,
  input  logic [CHAIN_LEN-1:0] wr_data,
  output logic                 busy,
  output logic                 done,
  output logic [CHAIN_LEN-1:0] rd_data,
  output logic                 ch_out,
  output logic                 ch_down,
  output logic                 ch_clk,
  output logic                 ch_load,
  input  logic                 ch_in,
  input  logic                 gpo_we,
  input  logic [GPO_W-1:0]     gpo_wdata,
  output logic [GPO_W-1:0]     gpo,
  input  logic [GPI_W-1:0]     gpi,
  output logic [GPI_W-1:0]     gpi_q
);

  localparam int BIT_W = $clog2(CHAIN_LEN) + 1;
  localparam int DIV_W = $clog2(2 * CLK_DIV) + 1;
  localparam logic [DIV_W-1:0] PHASE_END = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] LOAD_END  = DIV_W'(2 * CLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(CHAIN_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_LOAD} state_t;

  state_t               st;
  logic [DIV_W-1:0]     div;
  logic [BIT_W-1:0]     bit_cnt;
  logic [CHAIN_LEN-1:0] sreg;
  logic [CHAIN_LEN-1:0] rbk;
  logic                 down_q;
  logic [GPI_W-1:0]     gpi_s1;

  assign busy    = (st != S_IDLE);
  assign ch_down = down_q;
  assign ch_out  = (st == S_LO || st == S_HI) ? sreg[0] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div     <= '0;
      bit_cnt <= '0;
      sreg    <= '0;
      rbk     <= '0;
      rd_data <= '0;
      down_q  <= 1'b0;
      ch_clk  <= 1'b0;
      ch_load <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      div  <= div + 1'b1;
      case (st)
        S_IDLE: begin
          div <= '0;
          if (start) begin
            sreg    <= wr_data;
            down_q  <= down_cfg;
            bit_cnt <= '0;
            st      <= S_LO;
          end
        end
        S_LO: if (div == PHASE_END) begin
          div    <= '0;
          ch_clk <= 1'b1;
          rbk    <= {ch_in, rbk[CHAIN_LEN-1:1]};
          st     <= S_HI;
        end
        S_HI: if (div == PHASE_END) begin
          div    <= '0;
          ch_clk <= 1'b0;
          sreg   <= sreg >> 1;
          if (bit_cnt == LAST_BIT) begin
            ch_load <= 1'b1;
            st      <= S_LOAD;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            st      <= S_LO;
          end
        end
        S_LOAD: if (div == LOAD_END) begin
          div     <= '0;
          ch_load <= 1'b0;
          down_q  <= 1'b0;
          done    <= 1'b1;
          rd_data <= rbk;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpo    <= '0;
      gpi_s1 <= '0;
      gpi_q  <= '0;
    end else begin
      if (gpo_we) gpo <= gpo_wdata;
      gpi_s1 <= gpi;
      gpi_q  <= gpi_s1;
    end
  end

endmodule

// File: rtl/fe_cfg_chain_chk.sv
module fe_cfg_chain_chk #(
  parameter int CHAIN_LEN = 48,
  parameter int CLK_DIV   = 2,
  parameter int GPO_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_clk,
  input logic             ch_load,
  input logic             ch_out,
  input logic             ch_down,
  input logic             busy,
  input logic             done,
  input logic             gpo_we,
  input logic [GPO_W-1:0] gpo_wdata,
  input logic [GPO_W-1:0] gpo
);

  logic [31:0] rise_cnt;
  logic [31:0] load_len;
  logic        clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      load_len <= '0;
      clk_d    <= 1'b0;
    end else begin
      clk_d <= ch_clk;
      if (!busy) rise_cnt <= '0;
      else if (ch_clk && !clk_d) rise_cnt <= rise_cnt + 1;
      load_len <= ch_load ? load_len + 1 : '0;
    end
  end

  // R2
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_load) |-> rise_cnt == CHAIN_LEN);

  // R3
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_clk && $past(ch_clk)) |-> $stable(ch_out));

  // R6
  load_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_load && ch_clk));

  // R6
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_load) |-> load_len == 2 * CLK_DIV);

  // R7
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ch_down));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ch_clk && !ch_load && !ch_down));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  gpo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpo_we |=> gpo == $past(gpo_wdata));

endmodule

bind fe_cfg_chain fe_cfg_chain_chk #(
  .CHAIN_LEN(CHAIN_LEN), .CLK_DIV(CLK_DIV), .GPO_W(GPO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk), .ch_load(ch_load),
  .ch_out(ch_out), .ch_down(ch_down), .busy(busy), .done(done),
  .gpo_we(gpo_we), .gpo_wdata(gpo_wdata), .gpo(gpo)
);

// File: tb/tb_fe_cfg_chain.sv
module tb_fe_cfg_chain;
  localparam int CLK_PERIOD = 10;
  localparam int CHIP_BITS  = 16;
  localparam int CHIPS      = 3;
  localparam int CLK_DIV    = 2;
  localparam int N          = CHIPS * CHIP_BITS;
  localparam int T          = 2 * CLK_DIV * (N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, down_cfg = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic busy, done, ch_out, ch_down, ch_clk, ch_load, ch_in;
  logic [N-1:0] rd_data;
  logic gpo_we = 1'b0;
  logic [11:0] gpo_wdata = '0, gpo;
  logic [2:0] gpi = '0, gpi_q;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_cfg_chain #(.CHIP_BITS(CHIP_BITS), .CHIPS(CHIPS), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .down_cfg(down_cfg), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .ch_out(ch_out), .ch_down(ch_down),
    .ch_clk(ch_clk), .ch_load(ch_load), .ch_in(ch_in), .gpo_we(gpo_we),
    .gpo_wdata(gpo_wdata), .gpo(gpo), .gpi(gpi), .gpi_q(gpi_q));

  // external chain model: cell 0 drives the return line
  logic [N-1:0] cells = '0;
  logic [N-1:0] shadow = '0;
  always @(posedge ch_clk) cells <= {ch_out, cells[N-1:1]};
  always @(posedge ch_load) shadow <= cells;
  assign ch_in = cells[0];

  int   rises = 0;
  logic exp_down = 1'b0, down_bad = 1'b0, out_bad = 1'b0;
  logic prev_out = 1'b0, prev_clk = 1'b0;
  always @(posedge ch_clk) begin
    rises++;
    if (ch_down !== exp_down) down_bad = 1'b1;
  end
  always @(negedge clk) begin
    if (ch_clk && prev_clk && ch_out !== prev_out) out_bad = 1'b1;
    prev_out = ch_out;
    prev_clk = ch_clk;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [N-1:0] prev_pat = '0;

  task automatic transfer(logic [N-1:0] pat, logic dn, bit inject);
    int cycles;
    @(negedge clk);
    wr_data = pat; down_cfg = dn; start = 1'b1;
    exp_down = dn; rises = 0; down_bad = 1'b0; out_bad = 1'b0;
    @(posedge clk); #1;
    start = 1'b0; wr_data = ~pat; down_cfg = ~dn;
    cycles = 0;
    while (!done && cycles < T + 50) begin
      @(posedge clk); #1;
      cycles++;
      if (start) begin start = 1'b0; wr_data = ~pat; end
      if (cycles == T / 2) begin
        chk("R6 shadow held while shifting", 64'(shadow), 64'(prev_pat));
        chk("R8 busy during transfer", 64'(busy), 64'd1);
        if (inject) begin start = 1'b1; wr_data = pat ^ N'(48'h0F0F_0F0F_0F0F); end
      end
    end
    chk("R8 transfer length", 64'(cycles), 64'(T));
    chk("R2 clock rises", 64'(rises), 64'(N));
    chk("R4 chain contents", 64'(cells), 64'(pat));
    chk("R6 shadow after load", 64'(shadow), 64'(pat));
    chk("R5 readback", 64'(rd_data), 64'(prev_pat));
    chk("R7 down level", 64'(down_bad), 64'd0);
    chk("R3 data stable high", 64'(out_bad), 64'd0);
    @(posedge clk); #1;
    chk("R8 done single pulse", 64'(done), 64'd0);
    chk("R9 R8 idle after", 64'(busy), 64'd0);
    chk("R7 down idle", 64'(ch_down), 64'd0);
    prev_pat = pat;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    #(CLK_PERIOD * 3 + 2);
    // R1
    chk("R1 ch_clk", 64'(ch_clk), 64'd0);
    chk("R1 ch_load", 64'(ch_load), 64'd0);
    chk("R1 ch_down", 64'(ch_down), 64'd0);
    chk("R1 ch_out", 64'(ch_out), 64'd0);
    chk("R1 busy done", 64'({busy, done}), 64'd0);
    chk("R1 gpo", 64'(gpo), 64'd0);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", 64'({busy, ch_clk, ch_load}), 64'd0);

    transfer('1, 1'b1, 1'b0);
    transfer('0, 1'b0, 1'b0);
    transfer(N'(48'h5555_5555_5555), 1'b1, 1'b0);
    transfer(N'(1), 1'b0, 1'b0);
    transfer(N'(1) << (N - 1), 1'b1, 1'b0);
    transfer(N'({$urandom(), $urandom()}), 1'b0, 1'b1); // R9
    for (int i = 0; i < 8; i++)
      transfer(N'({$urandom(), $urandom()}), 1'($urandom()), 1'b0);

    // R10
    for (int i = 0; i < 6; i++) begin
      logic [11:0] v;
      v = 12'($urandom());
      @(negedge clk); gpo_we = 1'b1; gpo_wdata = v;
      @(negedge clk); gpo_we = 1'b0; gpo_wdata = ~v;
      chk("R10 gpo written", 64'(gpo), 64'(v));
      @(negedge clk);
      chk("R10 gpo held", 64'(gpo), 64'(v));
    end

    // R11
    for (int i = 0; i < 4; i++) begin
      logic [2:0] g, old;
      old = gpi_q;
      g = 3'($urandom()) | 3'(i == 0);
      if (g == old) g = ~old;
      @(negedge clk); gpi = g;
      @(negedge clk);
      chk("R11 not after one edge", 64'(gpi_q), 64'(old));
      @(negedge clk);
      chk("R11 after two edges", 64'(gpi_q), 64'(g));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule